// File: doc/BRIEF.md
# DRAM Strobe-Cycle Controller with Compressed Test Mode

This block is a clocked model of the control front end of a strobe-driven dynamic memory. On every system clock it samples active-low row strobe, column strobe, write enable and output enable. It also samples a multiplexed address bus and a 4-bit data input. It works out the kind of each row-strobe cycle from the order in which the strobes fall. The four kinds are a normal access, a refresh with the column strobe first, a refresh with the row strobe alone, and a test-entry cycle that has both write and column strobe low before the row strobe. It keeps a flag that shows whether the internal parallel-test mode is active.

In normal mode the block reads and writes 4-bit words held in a small register array that is addressed by row and column. In test mode every data pin stands for four internal bits, which sit in the four columns that differ only in the two lowest column bits. A write copies each data bit into all four bits of its group. A read returns, for each pin, 1 when the group agrees and 0 when it does not. Storage is not really refreshed, and the analog timing of a real device is not modelled.

Top module: `dram_tm_ctrl`

## Requirements
- R1: After reset, test_active is 0, dq_drive is 0 and cycle_kind is 0 (access).
- R2: A row-strobe fall with column strobe and write enable already low sets test_active to 1 and cycle_kind to 3 on that edge. This also holds for the first cycle after reset.
- R3: A row-strobe fall with column strobe low and write enable high clears test_active and sets cycle_kind to 1.
- R4: A row-strobe cycle in which the column strobe stays high for the whole low period clears test_active and sets cycle_kind to 2 on the edge that samples the row strobe high again.
- R5: A test-entry cycle issued while test_active is 1 keeps test_active at 1 and sets cycle_kind to 3.
- R6: In normal mode, a column-strobe fall with write enable low stores dq_in at the latched row and column. A later read with output enable low returns that word on dq_out.
- R7: dq_drive is 0 whenever output enable is high, the column strobe is high, or the current access is a write.
- R8: In test mode, a write copies dq_in into all four columns that share the upper column bits. The two lowest column address bits have no effect.
- R9: In test mode, a read sets dq_out bit b to 1 when bit b is equal in all four words of the group, and to 0 when the words differ.
- R10: In test mode the row address still selects the row, so a test write leaves every other row unchanged.
- R11: Refresh cycles of either kind leave the stored contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Multiplexed row/column address |
| dq_in | input | 4 | Write data |
| dq_out | output | 4 | Read data, zero when not driven |
| dq_drive | output | 1 | High when dq_out is being driven |
| cycle_kind | output | 2 | 0 access, 1 column-first refresh, 2 row-only refresh, 3 test entry |
| test_active | output | 1 | Parallel-test mode flag |

## Verification
The cycle kind and the test flag change on the clock edge that samples the row-strobe fall. For a row-only refresh they change on the edge that samples the row strobe rising. Read data and dq_drive follow the edge that samples the column-strobe fall, and dq_drive then follows output enable combinationally. The bench drives every input just after a falling clock edge and queues the values it expects for the next falling edge. The monitor compares them there, half a period after the rising edge that took the sample, so each result is checked in the cycle in which it is due.

// File: rtl/dram_tm_pkg.sv
package dram_tm_pkg;

    localparam int DQ_W   = 4;
    localparam int GRP_N  = 4;
    localparam int GRP_LG = 2;

    typedef enum logic [1:0] {
        CYC_ACCESS = 2'd0,
        CYC_CBR    = 2'd1,
        CYC_RONLY  = 2'd2,
        CYC_WCBR   = 2'd3
    } cyc_kind_t;

    typedef struct packed {
        logic ras_fall;
        logic ras_rise;
        logic cas_fall;
    } strobe_ev_t;

    function automatic logic all_same(input logic [GRP_N-1:0] bits);
        return (&bits) | ~(|bits);
    endfunction

endpackage

// File: rtl/dram_strobe_decode.sv
module dram_strobe_decode
    import dram_tm_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] row_q,
    output logic [AW-1:0] col_q,
    output cyc_kind_t     kind_q,
    output logic          test_q,
    output logic          wr_en,
    output logic          col_valid,
    output logic          wr_cyc
);

    logic       ras_d, cas_d;
    logic       in_acc, cas_seen;
    strobe_ev_t ev;
    logic       acc_col;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_d <= 1'b1;
            cas_d <= 1'b1;
        end else begin
            ras_d <= ras_n;
            cas_d <= cas_n;
        end
    end

    always_comb begin
        ev.ras_fall = ras_d & ~ras_n;
        ev.ras_rise = ~ras_d & ras_n;
        ev.cas_fall = cas_d & ~cas_n;
    end

    assign acc_col   = ev.cas_fall & in_acc & ~ras_n & ~ev.ras_fall;
    assign wr_en     = acc_col & ~we_n;
    assign col_valid = in_acc & cas_seen & ~cas_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_acc   <= 1'b0;
            cas_seen <= 1'b0;
            wr_cyc   <= 1'b0;
            test_q   <= 1'b0;
            kind_q   <= CYC_ACCESS;
            row_q    <= '0;
            col_q    <= '0;
        end else if (ev.ras_fall) begin
            row_q    <= addr;
            cas_seen <= 1'b0;
            wr_cyc   <= 1'b0;
            if (!cas_n) begin
                in_acc <= 1'b0;
                if (!we_n) begin
                    kind_q <= CYC_WCBR;
                    test_q <= 1'b1;
                end else begin
                    kind_q <= CYC_CBR;
                    test_q <= 1'b0;
                end
            end else begin
                in_acc <= 1'b1;
                kind_q <= CYC_ACCESS;
            end
        end else if (ev.ras_rise) begin
            in_acc <= 1'b0;
            if (in_acc && !cas_seen) begin
                kind_q <= CYC_RONLY;
                test_q <= 1'b0;
            end
        end else if (acc_col) begin
            col_q    <= addr;
            cas_seen <= 1'b1;
            wr_cyc   <= ~we_n;
        end
    end

endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array
    import dram_tm_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic            test_mode,
    input  logic [AW-1:0]   wr_row,
    input  logic [AW-1:0]   wr_col,
    input  logic [DQ_W-1:0] wr_data,
    input  logic [AW-1:0]   rd_row,
    input  logic [AW-1:0]   rd_col,
    output logic [DQ_W-1:0] rd_data
);

    localparam int IW = 2 * AW;
    localparam int NW = 1 << IW;

    logic [DQ_W-1:0] mem [NW];
    logic [DQ_W-1:0] grp_w [GRP_N];
    logic [DQ_W-1:0] word_rd;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (test_mode) begin
                for (int k = 0; k < GRP_N; k++) begin
                    mem[{wr_row, wr_col[AW-1:GRP_LG], GRP_LG'(k)}] <= wr_data;
                end
            end else begin
                mem[{wr_row, wr_col}] <= wr_data;
            end
        end
    end

    always_comb begin
        word_rd = mem[{rd_row, rd_col}];
        for (int k = 0; k < GRP_N; k++) begin
            grp_w[k] = mem[{rd_row, rd_col[AW-1:GRP_LG], GRP_LG'(k)}];
        end
    end

    for (genvar b = 0; b < DQ_W; b++) begin : g_bit
        logic [GRP_N-1:0] slice;
        for (genvar k = 0; k < GRP_N; k++) begin : g_k
            assign slice[k] = grp_w[k][b];
        end
        assign rd_data[b] = test_mode ? all_same(slice) : word_rd[b];
    end

endmodule

// File: rtl/dram_tm_ctrl.sv
module dram_tm_ctrl
    import dram_tm_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [3:0]    dq_in,
    output logic [3:0]    dq_out,
    output logic          dq_drive,
    output logic [1:0]    cycle_kind,
    output logic          test_active
);

    logic [AW-1:0]   row_q, col_q;
    cyc_kind_t       kind_q;
    logic            test_q, wr_en, col_valid, wr_cyc;
    logic [DQ_W-1:0] rd_data;

    dram_strobe_decode #(.AW(AW)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .addr      (addr),
        .row_q     (row_q),
        .col_q     (col_q),
        .kind_q    (kind_q),
        .test_q    (test_q),
        .wr_en     (wr_en),
        .col_valid (col_valid),
        .wr_cyc    (wr_cyc)
    );

    dram_cell_array #(.AW(AW)) u_arr (
        .clk       (clk),
        .wr_en     (wr_en),
        .test_mode (test_q),
        .wr_row    (row_q),
        .wr_col    (addr),
        .wr_data   (dq_in),
        .rd_row    (row_q),
        .rd_col    (col_q),
        .rd_data   (rd_data)
    );

    assign dq_drive    = col_valid & ~oe_n & ~wr_cyc;
    assign dq_out      = dq_drive ? rd_data : '0;
    assign cycle_kind  = kind_q;
    assign test_active = test_q;

endmodule

// File: rtl/dram_tm_ctrl_chk.sv
module dram_tm_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic       oe_n,
    input logic       dq_drive,
    input logic [1:0] cycle_kind,
    input logic       test_active
);

    logic ras_prev, norm_cyc, saw_cas;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_prev <= 1'b1;
            norm_cyc <= 1'b0;
            saw_cas  <= 1'b0;
        end else begin
            ras_prev <= ras_n;
            if (ras_prev && !ras_n) begin
                norm_cyc <= cas_n;
                saw_cas  <= 1'b0;
            end else if (!ras_n && !cas_n) begin
                saw_cas <= 1'b1;
            end
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!test_active && !dq_drive && cycle_kind == 2'd0));

    a_r7_no_drive_when_idle: assert property (@(posedge clk) disable iff (rst)
        (oe_n || cas_n) |-> !dq_drive);

    a_r2_entry_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (ras_prev && !ras_n && !cas_n && !we_n) |=> (test_active && cycle_kind == 2'd3));

    a_r3_cbr_clears_flag: assert property (@(posedge clk) disable iff (rst)
        (ras_prev && !ras_n && !cas_n && we_n) |=> (!test_active && cycle_kind == 2'd1));

    a_r4_ras_only_clears: assert property (@(posedge clk) disable iff (rst)
        (!ras_prev && ras_n && norm_cyc && !saw_cas) |=> (!test_active && cycle_kind == 2'd2));

endmodule

bind dram_tm_ctrl dram_tm_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .oe_n        (oe_n),
    .dq_drive    (dq_drive),
    .cycle_kind  (cycle_kind),
    .test_active (test_active)
);

// File: tb/tb_dram_tm_ctrl.sv
`timescale 1ns/1ps
module tb_dram_tm_ctrl;

    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [3:0]    dq_in = '0;
    logic [3:0]    dq_out;
    logic          dq_drive;
    logic [1:0]    cycle_kind;
    logic          test_active;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        string      req;
        int         what;   // 0 test flag, 1 drive, 2 data, 3 kind
        logic [3:0] exp;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    dram_tm_ctrl #(.AW(AW)) dut (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_drive(dq_drive), .cycle_kind(cycle_kind), .test_active(test_active)
    );

    // monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            logic [3:0] act;
            e = sb.pop_front();
            case (e.what)
                0: act = {3'b0, test_active};
                1: act = {3'b0, dq_drive};
                2: act = dq_out;
                default: act = {2'b0, cycle_kind};
            endcase
            checks++;
            if (act !== e.exp) begin
                failures++;
                $display("FAIL %s what=%0d actual=%h expected=%h", e.req, e.what, act, e.exp);
            end
        end
    end

    task automatic push(input string req, input int what, input logic [3:0] exp);
        exp_t e;
        e.req = req; e.what = what; e.exp = exp;
        sb.push_back(e);
    endtask

    task automatic look();
        @(negedge clk);
        #1;
    endtask

    task automatic release_all();
        cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        look();
        ras_n = 1'b1;
        look();
        look();
    endtask

    task automatic write_word(input logic [AW-1:0] row, input logic [AW-1:0] col,
                              input logic [3:0] d, input bit chk_drive);
        addr = row; ras_n = 1'b0;
        look();
        addr = col; dq_in = d; we_n = 1'b0; oe_n = chk_drive ? 1'b0 : 1'b1; cas_n = 1'b0;
        if (chk_drive) push("R7", 1, 4'd0);
        look();
        release_all();
    endtask

    task automatic read_word(input string req, input logic [AW-1:0] row,
                             input logic [AW-1:0] col, input logic [3:0] exp);
        addr = row; ras_n = 1'b0;
        look();
        addr = col; cas_n = 1'b0; oe_n = 1'b1;
        push("R7", 1, 4'd0);
        look();
        oe_n = 1'b0;
        push(req, 1, 4'd1);
        push(req, 2, exp);
        look();
        release_all();
    endtask

    task automatic cas_first(input string req, input bit we_low, input logic [1:0] kind,
                             input bit flag);
        cas_n = 1'b0; we_n = we_low ? 1'b0 : 1'b1;
        look();
        ras_n = 1'b0;
        push(req, 3, {2'b0, kind});
        push(req, 0, {3'b0, flag});
        look();
        release_all();
    endtask

    task automatic ras_only(input logic [AW-1:0] row);
        addr = row; ras_n = 1'b0;
        look();
        look();
        ras_n = 1'b1;
        push("R4", 3, 4'd2);
        push("R4", 0, 4'd0);
        look();
    endtask

    initial begin
        repeat (3) look();
        rst = 1'b0;
        push("R1", 0, 4'd0);
        push("R1", 1, 4'd0);
        push("R1", 3, 4'd0);
        look();

        // R6: normal writes and reads
        write_word(3'd1, 3'd5, 4'hA, 1'b1);
        write_word(3'd2, 3'd3, 4'h5, 1'b0);
        write_word(3'd1, 3'd4, 4'hC, 1'b0);
        for (int c = 0; c < 8; c++) write_word(3'd3, 3'(c), 4'(c ^ 9), 1'b0);
        read_word("R6", 3'd1, 3'd5, 4'hA);
        read_word("R6", 3'd2, 3'd3, 4'h5);
        read_word("R6", 3'd1, 3'd4, 4'hC);
        for (int c = 0; c < 8; c++) read_word("R6", 3'd3, 3'(c), 4'(c ^ 9));

        // setup for R9 / R10
        write_word(3'd6, 3'd0, 4'hF, 1'b0);
        write_word(3'd6, 3'd1, 4'hE, 1'b0);
        write_word(3'd6, 3'd2, 4'hF, 1'b0);
        write_word(3'd6, 3'd3, 4'hF, 1'b0);
        write_word(3'd5, 3'd4, 4'h3, 1'b0);

        // R11: refresh of both kinds keeps contents
        cas_first("R3", 1'b0, 2'd1, 1'b0);
        ras_only(3'd1);
        read_word("R11", 3'd1, 3'd5, 4'hA);
        read_word("R11", 3'd2, 3'd3, 4'h5);

        // R2: test entry
        cas_first("R2", 1'b1, 2'd3, 1'b1);
        // R8: broadcast write, low column bits given as 01
        write_word(3'd4, 3'd5, 4'hA, 1'b0);
        // R9: compare reads
        read_word("R9", 3'd6, 3'd2, 4'hE);
        read_word("R9", 3'd4, 3'd6, 4'hF);
        // R5: entry again while in test mode
        cas_first("R5", 1'b1, 2'd3, 1'b1);
        // R3: leave test mode
        cas_first("R3", 1'b0, 2'd1, 1'b0);
        for (int c = 4; c < 8; c++) read_word("R8", 3'd4, 3'(c), 4'hA);
        read_word("R10", 3'd5, 3'd4, 4'h3);
        read_word("R10", 3'd6, 3'd1, 4'hE);

        // R4: row-only refresh leaves test mode
        cas_first("R2", 1'b1, 2'd3, 1'b1);
        ras_only(3'd2);

        // R2: entry as the first cycle after reset
        rst = 1'b1;
        look(); look();
        rst = 1'b0;
        push("R1", 0, 4'd0);
        look();
        cas_first("R2", 1'b1, 2'd3, 1'b1);

        look();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule